// File: doc/BRIEF.md
# Table-Routed Mesh Router with Gateway Fallback

This block is the switching element of one tile in an on-chip mesh. It moves flit streams between six full-duplex ports: a local network-interface port, four neighbour ports and one port that leads to an off-chip wireless gateway. Each input has a small FIFO. A head flit at the front of an input FIFO picks its output by looking up its destination ID in a programmable routing table. A destination that has no valid entry, or whose entry names a port that does not exist, goes to the gateway port. Each output has a round-robin arbiter. The arbiter keeps the path open from head to tail, so packets never interleave on a link.

A table-loading agent outside the block fills the table one entry per cycle through an ID/port/valid write port. Every port uses valid/ready flow control. A flit moves only in a cycle where valid and ready are both high.

Two state machines carry the control. Each input runs `IP_IDLE` and `IP_PKT`. It moves from `IP_IDLE` to `IP_PKT` when a head or single flit is at its FIFO front, and it latches the route at that point. It returns to `IP_IDLE` when its tail or single flit leaves. In `IP_IDLE` it drops any body or tail flit that reaches the front. Each output runs `OA_FREE` and `OA_BUSY`. It moves from `OA_FREE` to `OA_BUSY` when at least one input requests it, and it records the winner as owner. It returns to `OA_FREE` when the owner's closing flit transfers, and it then moves its priority pointer to the port after the owner.

Top module: `mesh_table_router`

## Requirements
- R1: After reset, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: A packet whose destination ID has a valid table entry naming port 0 to 5 leaves on that port. All its flits leave unchanged and in order. Ports are 0 local, 1 north, 2 east, 3 south, 4 west, 5 gateway.
- R3: A destination ID whose entry was never written, or was last written with `tbl_ok`=0, sends the packet to port 5.
- R4: A valid entry that holds port code 6 or 7 counts as a miss and sends the packet to port 5.
- R5: A flit is {kind[1:0], payload[15:0]}. The kind codes are 00 head, 01 body, 10 tail and 11 single, where a single flit is a complete one-flit packet. A head or single flit carries its destination ID in payload bits [7:0].
- R6: Once an output has accepted a head flit from an input, no flit from any other input appears on that output until the packet's tail flit has passed.
- R7: When several inputs wait for a free output, the output grants the first requester found at or after the port that follows the previous owner, wrapping from 5 to 0. After reset the search starts at port 0.
- R8: Packets from different inputs to different outputs transfer in the same cycle.
- R9: While `out_valid` is high and `out_ready` is low, the output holds its flit stable, and no flit is lost or repeated.
- R10: Each input FIFO holds 4 flits. `in_ready` drops when 4 flits are stored and none can leave.
- R11: A body or tail flit that reaches an input front while no packet is open on that input is discarded and appears on no output.
- R12: Suppose a single flit is accepted at clock edge k into an idle input whose output is free and ready. It is presented on the output after edge k+2 and transfers at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_flit | input | NP*FW | Incoming flits, port p in bits [p*FW +: FW] |
| in_valid | input | NP | Incoming flit valid per port |
| in_ready | output | NP | Input FIFO can accept per port |
| out_flit | output | NP*FW | Outgoing flits, port p in bits [p*FW +: FW] |
| out_valid | output | NP | Outgoing flit valid per port |
| out_ready | input | NP | Downstream can accept per port |
| tbl_we | input | 1 | Routing-table write enable |
| tbl_id | input | ID_W | Destination ID being written |
| tbl_port | input | PW | Output port stored for that ID |
| tbl_ok | input | 1 | Valid bit stored for that ID |

## Verification
Two functions can fall in the same cycle: arbitration among several inputs that want one output, and concurrent transfer on unrelated outputs. The bench provokes contention by holding an output's ready low while two inputs load single flits in the same cycle. It then releases ready and judges the order of arrival against the rotating pointer. A second round is chosen so that fixed priority would give the opposite order. Parallel transfer is judged by recording the cycle number of each output transfer and requiring two disjoint routes to move in the same cycle. Path locking is checked in the same way: a multi-flit packet races a single flit, and the bench requires the multi-flit packet to arrive contiguous.

// File: rtl/mtr_pkg.sv
package mtr_pkg;
    typedef enum logic [1:0] {
        FK_HEAD   = 2'b00,
        FK_BODY   = 2'b01,
        FK_TAIL   = 2'b10,
        FK_SINGLE = 2'b11
    } flit_kind_e;

    typedef enum logic {IP_IDLE, IP_PKT} ip_state_e;
    typedef enum logic {OA_FREE, OA_BUSY} oa_state_e;
endpackage

// File: rtl/rt_route_table.sv
module rt_route_table #(
    parameter int NP   = 6,
    parameter int ID_W = 8,
    parameter int PW   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [ID_W-1:0]    wid,
    input  logic [PW-1:0]      wport,
    input  logic               wok,
    input  logic [NP*ID_W-1:0] lk_id,
    output logic [NP*PW-1:0]   lk_port
);
    localparam int DEPTH = 1 << ID_W;
    localparam logic [PW-1:0] GW = PW'(NP - 1);

    logic [PW-1:0]    port_mem [DEPTH];
    logic [DEPTH-1:0] ok_mem;

    always_ff @(posedge clk) begin
        if (!rst_n)  ok_mem <= '0;
        else if (we) ok_mem[wid] <= wok;
    end

    always_ff @(posedge clk) begin
        if (we) port_mem[wid] <= wport;
    end

    for (genvar g = 0; g < NP; g++) begin : g_rd
        logic [ID_W-1:0] id;
        logic            hit;
        assign id  = lk_id[g*ID_W +: ID_W];
        assign hit = ok_mem[id] && (int'(port_mem[id]) < NP);
        assign lk_port[g*PW +: PW] = hit ? port_mem[id] : GW;
    end
endmodule

// File: rtl/rt_in_port.sv
module rt_in_port
    import mtr_pkg::*;
#(
    parameter int FW    = 18,
    parameter int DEPTH = 4,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] in_flit,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          pop,
    input  logic [PW-1:0] route_in,
    output logic [FW-1:0] fr_flit,
    output logic          fr_valid,
    output logic          pkt_req,
    output logic [PW-1:0] route_q
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [FW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;
    logic          push, deq, drop, nonempty, starts, ends;
    ip_state_e     st, nx;

    assign push     = in_valid && in_ready;
    assign deq      = pop || drop;
    assign nonempty = (cnt != '0);
    assign fr_flit  = mem[rp];
    assign starts   = (fr_flit[FW-1] == fr_flit[FW-2]);
    assign ends     = fr_flit[FW-1];

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= in_flit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (deq)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + (AW+1)'(push) - (AW+1)'(deq);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= IP_IDLE;
            route_q <= '0;
        end else begin
            st <= nx;
            if (st == IP_IDLE && nonempty && starts) route_q <= route_in;
        end
    end

    always_comb begin
        nx   = st;
        drop = 1'b0;
        unique case (st)
            IP_IDLE: if (nonempty) begin
                if (starts) nx = IP_PKT;
                else        drop = 1'b1;
            end
            IP_PKT: if (pop && ends) nx = IP_IDLE;
        endcase
    end

    always_comb begin
        in_ready = (cnt != (AW+1)'(DEPTH));
        pkt_req  = (st == IP_PKT);
        fr_valid = pkt_req && nonempty;
    end

    always_ff @(posedge clk) begin
        if (rst_n) AST_FIFO_BOUND: assert (int'(cnt) <= DEPTH); // R10
    end

    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> fr_valid); // R9
endmodule

// File: rtl/rt_out_arb.sv
module rt_out_arb
    import mtr_pkg::*;
#(
    parameter int NP = 6,
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NP-1:0] req,
    input  logic          fire,
    input  logic          last,
    output logic          busy,
    output logic [PW-1:0] owner
);
    oa_state_e     st, nx;
    logic [PW-1:0] rr_q, win;
    logic          any;

    always_comb begin
        any = 1'b0;
        win = '0;
        for (int k = 0; k < NP; k++) begin : scan
            int idx;
            idx = (int'(rr_q) + k) % NP;
            if (!any && req[idx]) begin
                any = 1'b1;
                win = PW'(idx);
            end
        end
    end

    always_comb begin
        nx = st;
        unique case (st)
            OA_FREE: if (any)         nx = OA_BUSY;
            OA_BUSY: if (fire && last) nx = OA_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= OA_FREE;
            owner <= '0;
            rr_q  <= '0;
        end else begin
            st <= nx;
            if (st == OA_FREE && any) owner <= win;
            if (st == OA_BUSY && fire && last)
                rr_q <= (int'(owner) == NP - 1) ? '0 : owner + 1'b1;
        end
    end

    assign busy = (st == OA_BUSY);

    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !(fire && last) |=> busy && $stable(owner)); // R6
    AST_OWNER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> req[owner]); // R6
endmodule

// File: rtl/mesh_table_router.sv
module mesh_table_router
    import mtr_pkg::*;
#(
    parameter int NP     = 6,
    parameter int DW     = 16,
    parameter int ID_W   = 8,
    parameter int FIFO_D = 4,
    parameter int FW     = DW + 2,
    parameter int PW     = $clog2(NP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NP*FW-1:0]   in_flit,
    input  logic [NP-1:0]      in_valid,
    output logic [NP-1:0]      in_ready,
    output logic [NP*FW-1:0]   out_flit,
    output logic [NP-1:0]      out_valid,
    input  logic [NP-1:0]      out_ready,
    input  logic               tbl_we,
    input  logic [ID_W-1:0]    tbl_id,
    input  logic [PW-1:0]      tbl_port,
    input  logic               tbl_ok
);
    logic [FW-1:0]      fr_flit [NP];
    logic [PW-1:0]      route_q [NP];
    logic [PW-1:0]      owner   [NP];
    logic [NP-1:0]      req_to  [NP];
    logic [NP-1:0]      own_col [NP];
    logic [NP-1:0]      fr_valid, pkt_req, pop, busy, fire, last;
    logic [NP*ID_W-1:0] lk_id;
    logic [NP*PW-1:0]   lk_port;

    rt_route_table #(.NP(NP), .ID_W(ID_W), .PW(PW)) u_tbl (
        .clk(clk), .rst_n(rst_n), .we(tbl_we), .wid(tbl_id),
        .wport(tbl_port), .wok(tbl_ok), .lk_id(lk_id), .lk_port(lk_port)
    );

    for (genvar g = 0; g < NP; g++) begin : g_in
        assign lk_id[g*ID_W +: ID_W] = fr_flit[g][ID_W-1:0];
        rt_in_port #(.FW(FW), .DEPTH(FIFO_D), .PW(PW)) u_in (
            .clk(clk), .rst_n(rst_n),
            .in_flit(in_flit[g*FW +: FW]), .in_valid(in_valid[g]),
            .in_ready(in_ready[g]), .pop(pop[g]),
            .route_in(lk_port[g*PW +: PW]), .fr_flit(fr_flit[g]),
            .fr_valid(fr_valid[g]), .pkt_req(pkt_req[g]), .route_q(route_q[g])
        );
    end

    for (genvar g = 0; g < NP; g++) begin : g_out
        rt_out_arb #(.NP(NP), .PW(PW)) u_arb (
            .clk(clk), .rst_n(rst_n), .req(req_to[g]),
            .fire(fire[g]), .last(last[g]), .busy(busy[g]), .owner(owner[g])
        );
    end

    always_comb begin
        pop = '0;
        for (int o = 0; o < NP; o++) begin
            for (int i = 0; i < NP; i++) begin
                req_to[o][i]  = pkt_req[i] && (int'(route_q[i]) == o);
                own_col[i][o] = busy[o] && (int'(owner[o]) == i);
            end
            out_valid[o]          = busy[o] && fr_valid[owner[o]];
            out_flit[o*FW +: FW]  = fr_flit[owner[o]];
            fire[o]               = out_valid[o] && out_ready[o];
            last[o]               = fr_flit[owner[o]][FW-1];
            if (fire[o]) pop[owner[o]] = 1'b1;
        end
    end

    for (genvar g = 0; g < NP; g++) begin : g_chk
        AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(own_col[g])); // R6
        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[g] && !out_ready[g] |=> out_valid[g] && $stable(out_flit[g*FW +: FW])); // R9
    end
endmodule

// File: tb/mesh_table_router_test.sv
module mesh_table_router_test;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 6;
    localparam int FW = 18;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP*FW-1:0] in_flit = '0;
    logic [NP-1:0]   in_valid = '0;
    logic [NP-1:0]   in_ready;
    logic [NP*FW-1:0] out_flit;
    logic [NP-1:0]   out_valid;
    logic [NP-1:0]   out_ready = '1;
    logic            tbl_we = 1'b0;
    logic [7:0]      tbl_id = '0;
    logic [2:0]      tbl_port = '0;
    logic            tbl_ok = 1'b0;

    mesh_table_router uut (
        .clk(clk), .rst_n(rst_n), .in_flit(in_flit), .in_valid(in_valid),
        .in_ready(in_ready), .out_flit(out_flit), .out_valid(out_valid),
        .out_ready(out_ready), .tbl_we(tbl_we), .tbl_id(tbl_id),
        .tbl_port(tbl_port), .tbl_ok(tbl_ok)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int nchk = 0, nerr = 0, cyc = 0;
    bit done = 0;
    logic [FW-1:0] rx  [NP][32];
    int            rxc [NP][32];
    int            rxn [NP];

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (out_valid[p] && out_ready[p] && rxn[p] < 32) begin
                    rx[p][rxn[p]]  = out_flit[p*FW +: FW];
                    rxc[p][rxn[p]] = cyc;
                    rxn[p]++;
                end
            end
        end
    end

    // src, dest ID, length, expected port
    localparam logic [16:0] VEC [11] = '{
        {3'd0, 8'h10, 3'd1, 3'd0},   // R2 single to local
        {3'd1, 8'h11, 3'd3, 3'd1},   // R2
        {3'd2, 8'h12, 3'd2, 3'd2},   // R2
        {3'd3, 8'h13, 3'd4, 3'd3},   // R2
        {3'd4, 8'h14, 3'd1, 3'd4},   // R2
        {3'd0, 8'h15, 3'd3, 3'd5},   // R2 programmed gateway
        {3'd1, 8'h20, 3'd2, 3'd5},   // R3 written invalid
        {3'd2, 8'h30, 3'd1, 3'd5},   // R3 never written
        {3'd3, 8'h21, 3'd2, 3'd5},   // R4 code 6
        {3'd4, 8'h22, 3'd1, 3'd5},   // R4 code 7
        {3'd5, 8'h12, 3'd3, 3'd2}    // R2 inbound from gateway
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // R5 flit encoding
    function automatic logic [FW-1:0] mk(input int len, input int k, input logic [7:0] dst, input logic [7:0] tag);
        logic [1:0] kind;
        if (len == 1)        kind = 2'b11;
        else if (k == 0)     kind = 2'b00;
        else if (k == len-1) kind = 2'b10;
        else                 kind = 2'b01;
        return {kind, tag, (k == 0) ? dst : 8'(k)};
    endfunction

    task automatic push(input int p, input logic [FW-1:0] f);
        in_flit[p*FW +: FW] = f;
        in_valid[p] = 1'b1;
        while (!in_ready[p]) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid[p] = 1'b0;
    endtask

    task automatic send_pkt(input int p, input logic [7:0] dst, input int len, input logic [7:0] tag);
        for (int k = 0; k < len; k++) push(p, mk(len, k, dst, tag));
    endtask

    task automatic twr(input logic [7:0] id, input logic [2:0] port, input logic ok);
        tbl_we = 1'b1; tbl_id = id; tbl_port = port; tbl_ok = ok;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic clear_rx();
        for (int p = 0; p < NP; p++) rxn[p] = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 6; p++) twr(8'h10 + 8'(p), 3'(p), 1'b1);
        twr(8'h20, 3'd1, 1'b1);
        twr(8'h20, 3'd1, 1'b0);
        twr(8'h21, 3'd6, 1'b1);
        twr(8'h22, 3'd7, 1'b1);
        clear_rx();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin : main
        clear_rx();
        repeat (2) @(negedge clk);
        chk(out_valid == '0, "R1 out_valid after reset", 32'(out_valid), 0);
        chk(in_ready == '1, "R1 in_ready after reset", 32'(in_ready), 32'h3f);
        do_reset();

        for (int v = 0; v < 11; v++) begin
            int src, len, ep, tot;
            logic [7:0] dst;
            src = int'(VEC[v][16:14]); dst = VEC[v][13:6];
            len = int'(VEC[v][5:3]);   ep  = int'(VEC[v][2:0]);
            clear_rx();
            send_pkt(src, dst, len, 8'(v + 8'h40));
            repeat (12) @(negedge clk);
            chk(rxn[ep] == len, "R2 R3 R4 flit count on expected port", rxn[ep], len);
            for (int k = 0; k < len; k++)
                chk(rx[ep][k] == mk(len, k, dst, 8'(v + 8'h40)), "R2 R5 flit content/order",
                    32'(rx[ep][k]), 32'(mk(len, k, dst, 8'(v + 8'h40))));
            tot = 0;
            for (int p = 0; p < NP; p++) tot += rxn[p];
            chk(tot == len, "R2 no flits on other ports", tot, len);
        end

        // R7 round robin, two rounds
        do_reset();
        out_ready[0] = 1'b0;
        fork
            push(1, mk(1, 0, 8'h10, 8'hA1));
            push(3, mk(1, 0, 8'h10, 8'hA3));
        join
        repeat (3) @(negedge clk);
        out_ready[0] = 1'b1;
        repeat (8) @(negedge clk);
        chk(rxn[0] == 2 && rx[0][0] == mk(1, 0, 8'h10, 8'hA1), "R7 first grant after reset", 32'(rx[0][0]), 32'(mk(1, 0, 8'h10, 8'hA1)));
        chk(rx[0][1] == mk(1, 0, 8'h10, 8'hA3), "R7 second grant", 32'(rx[0][1]), 32'(mk(1, 0, 8'h10, 8'hA3)));
        clear_rx();
        out_ready[0] = 1'b0;
        fork
            push(3, mk(1, 0, 8'h10, 8'hB3));
            push(4, mk(1, 0, 8'h10, 8'hB4));
        join
        repeat (3) @(negedge clk);
        out_ready[0] = 1'b1;
        repeat (8) @(negedge clk);
        chk(rxn[0] == 2 && rx[0][0] == mk(1, 0, 8'h10, 8'hB4), "R7 rotated priority", 32'(rx[0][0]), 32'(mk(1, 0, 8'h10, 8'hB4)));

        // R6 path lock
        clear_rx();
        fork
            send_pkt(1, 8'h10, 3, 8'hC1);
            push(2, mk(1, 0, 8'h10, 8'hC2));
        join
        repeat (10) @(negedge clk);
        begin
            bit a, b;
            a = rx[0][0] == mk(3, 0, 8'h10, 8'hC1) && rx[0][1] == mk(3, 1, 8'h10, 8'hC1) && rx[0][2] == mk(3, 2, 8'h10, 8'hC1);
            b = rx[0][1] == mk(3, 0, 8'h10, 8'hC1) && rx[0][2] == mk(3, 1, 8'h10, 8'hC1) && rx[0][3] == mk(3, 2, 8'h10, 8'hC1);
            chk(rxn[0] == 4 && (a || b), "R6 packet contiguous", rxn[0], 4);
        end

        // R8 parallel transfer
        clear_rx();
        fork
            push(1, mk(1, 0, 8'h12, 8'hD1));
            push(3, mk(1, 0, 8'h14, 8'hD3));
        join
        repeat (8) @(negedge clk);
        chk(rxn[2] == 1 && rxn[4] == 1 && rxc[2][0] == rxc[4][0], "R8 same-cycle transfer", rxc[2][0], rxc[4][0]);

        // R9 backpressure
        clear_rx();
        out_ready[4] = 1'b0;
        push(0, mk(1, 0, 8'h14, 8'hE0));
        repeat (5) @(negedge clk);
        chk(out_valid[4] == 1'b1, "R9 valid held under backpressure", 32'(out_valid[4]), 1);
        chk(out_flit[4*FW +: FW] == mk(1, 0, 8'h14, 8'hE0), "R9 flit held", 32'(out_flit[4*FW +: FW]), 32'(mk(1, 0, 8'h14, 8'hE0)));
        out_ready[4] = 1'b1;
        repeat (5) @(negedge clk);
        chk(rxn[4] == 1, "R9 delivered exactly once", rxn[4], 1);

        // R10 FIFO depth
        clear_rx();
        out_ready[0] = 1'b0;
        for (int k = 0; k < 4; k++) push(2, mk(5, k, 8'h10, 8'hF2));
        chk(in_ready[2] == 1'b0, "R10 full after 4 flits", 32'(in_ready[2]), 0);
        out_ready[0] = 1'b1;
        push(2, mk(5, 4, 8'h10, 8'hF2));
        repeat (10) @(negedge clk);
        chk(rxn[0] == 5 && rx[0][4] == mk(5, 4, 8'h10, 8'hF2), "R10 all five delivered", rxn[0], 5);

        // R11 stray flit discarded
        clear_rx();
        push(3, {2'b01, 16'h1313});
        push(3, mk(1, 0, 8'h13, 8'h77));
        repeat (8) @(negedge clk);
        chk(rxn[3] == 1 && rx[3][0] == mk(1, 0, 8'h13, 8'h77), "R11 stray dropped", 32'(rx[3][0]), 32'(mk(1, 0, 8'h13, 8'h77)));
        begin
            int tot = 0;
            for (int p = 0; p < NP; p++) tot += rxn[p];
            chk(tot == 1, "R11 nothing else emitted", tot, 1);
        end

        // R12 latency
        clear_rx();
        begin
            int t0;
            push(0, mk(1, 0, 8'h12, 8'h99));
            t0 = cyc;
            repeat (6) @(negedge clk);
            chk(rxn[2] == 1 && rxc[2][0] - t0 == 2, "R12 latency", rxc[2][0] - t0, 2);
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule